// File: doc/BRIEF.md
# Self-Test Launch and Skip Controller

This block sits between a power-state sequencer and a set of self-test engines. It receives a boot request, tagged with the path through which the device came up, or a runtime self-test request. It decides which engines take part and fires a one-cycle start pulse to each of them at the same time. It then tracks every started engine until the slowest one reports done. The result is the AND of the pass signals of the started engines. Engines that were not started count as passed, and anything they report is ignored.

There are four engines. The logic self-test can be skipped, and the rule that decides this depends on the entry path. On a cold power-up a non-volatile fast-boot bit skips it. After a wake from standby a software fast-test bit skips it. On entry from safe-recovery it is skipped automatically, unless the logic self-test has failed before. The analog core test always runs. The register/SRAM CRC test and the voltage-monitor test each run only when their own enable is set.

A runtime request runs every enabled engine, including the logic self-test. While a runtime test is running, the block raises a signal that tells the serial interfaces to ignore all traffic. Every completion sets either a pass flag or a fail flag. Both flags are write-1-to-clear. An active-low interrupt line is held low while either flag is set.

Top module: `selftest_launch`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the outputs are idle: eng_start=0, test_done=0, busy=0, if_ignore=0, both flags clear, int_n=1.
- R2: A boot request with entry_path=2'b00 (cold) or 2'b11 (reserved, treated as cold) starts the logic engine (bit 0) only when nvm_fast_boot=0. sw_fast_test and lbist_failed_before have no effect on this path.
- R3: A boot request with entry_path=2'b01 (wake from standby) starts the logic engine only when sw_fast_test=0. nvm_fast_boot has no effect on this path.
- R4: A boot request with entry_path=2'b10 (safe-recovery) starts the logic engine only when lbist_failed_before=1. The fast bits have no effect on this path.
- R5: The analog core engine (bit 1) starts on every request. The CRC engine (bit 2) starts only when crc_en=1. The monitor engine (bit 3) starts only when vmon_en=1.
- R6: eng_start carries the selected mask for exactly one cycle. That cycle is the first one after the edge at which the request was accepted, and it is also the first cycle in which busy is high.
- R7: test_done pulses for one cycle, in the cycle after the edge at which the last outstanding started engine's eng_done is sampled. busy falls in that same cycle.
- R8: Overall pass is the AND of eng_pass over the started engines, each taken in the cycle its eng_done is high. eng_done and eng_pass from engines that were not started, or that have already finished, are ignored.
- R9: A runtime request (rt_req) starts the logic engine whatever the entry path and the skip bits are, and follows R5 for the other engines. if_ignore is high exactly while a runtime test is busy.
- R10: At test_done, flag_pass is set if the test passed and flag_fail is set if it failed. The other flag keeps its value. clr_pass and clr_fail each clear their own flag, and a set in the same cycle wins over a clear. int_n is low while either flag is set.
- R11: Requests that arrive while busy=1 are ignored. If boot_req and rt_req are both high on an idle cycle, the boot request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req | input | 1 | Boot self-test request, taken when idle |
| entry_path | input | 2 | 00 cold, 01 wake, 10 safe-recovery, 11 treated as cold |
| nvm_fast_boot | input | 1 | Skip the logic test on cold entry |
| sw_fast_test | input | 1 | Skip the logic test on wake entry |
| lbist_failed_before | input | 1 | The logic test has failed before (recovery path) |
| crc_en | input | 1 | Enable for the register/SRAM CRC engine |
| vmon_en | input | 1 | Enable for the voltage-monitor test engine |
| rt_req | input | 1 | Runtime self-test request |
| eng_done | input | 4 | Per-engine done pulse |
| eng_pass | input | 4 | Per-engine pass, valid with eng_done |
| clr_pass | input | 1 | Write-1-to-clear for flag_pass |
| clr_fail | input | 1 | Write-1-to-clear for flag_fail |
| eng_start | output | 4 | Per-engine start pulse |
| test_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A test is running |
| if_ignore | output | 1 | Serial interfaces must ignore traffic |
| flag_pass | output | 1 | Sticky pass flag |
| flag_fail | output | 1 | Sticky fail flag |
| int_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the engines raise eng_done only after their start pulse, and that the software clear strobes are single-cycle writes. A clear seen on the falling edge of a flag is assumed to be the cause of that fall. The bench engine stubs count a configured latency of at least one cycle from each start pulse, so done never arrives in the start cycle. Stray done/pass pulses are injected only on engines that were not started, which is the stimulus the block must ignore. Clears and new requests are driven on single cycles between edges, including requests made while a test is busy.

// File: rtl/stl_pkg.sv
package stl_pkg;
  localparam int ENG_N      = 4;
  localparam int ENG_LOGIC  = 0;
  localparam int ENG_ANALOG = 1;
  localparam int ENG_CRC    = 2;
  localparam int ENG_VMON   = 3;
  localparam int PATH_W     = 2;

  typedef enum logic [PATH_W-1:0] {
    PATH_COLD  = 2'b00,
    PATH_WAKE  = 2'b01,
    PATH_RECOV = 2'b10,
    PATH_RSVD  = 2'b11
  } path_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/stl_skip_sel.sv
module stl_skip_sel
  import stl_pkg::*;
(
  input  logic [PATH_W-1:0] path,
  input  logic              runtime,
  input  logic              nvm_fast_boot,
  input  logic              sw_fast_test,
  input  logic              lbist_failed_before,
  input  logic              crc_en,
  input  logic              vmon_en,
  output logic [ENG_N-1:0]  sel
);
  logic run_logic;

  always_comb begin
    if (runtime) begin
      run_logic = 1'b1;
    end else begin
      case (path_e'(path))
        PATH_WAKE:  run_logic = !sw_fast_test;
        PATH_RECOV: run_logic = lbist_failed_before;
        default:    run_logic = !nvm_fast_boot;
      endcase
    end
  end

  always_comb begin
    sel             = '0;
    sel[ENG_LOGIC]  = run_logic;
    sel[ENG_ANALOG] = 1'b1;
    sel[ENG_CRC]    = crc_en;
    sel[ENG_VMON]   = vmon_en;
  end
endmodule

// File: rtl/stl_collect.sv
module stl_collect
  import stl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ENG_N-1:0] sel,
  input  logic             active,
  input  logic [ENG_N-1:0] done,
  input  logic [ENG_N-1:0] pass,
  output logic             all_done,
  output logic             any_fail
);
  logic [ENG_N-1:0] pend_q, pend_d, hit;
  logic             fail_q, fail_d, new_fail;
  logic             en;

  always_comb begin
    hit      = pend_q & done;
    new_fail = |(hit & ~pass);
    all_done = active && ((pend_q & ~done) == '0);
    any_fail = fail_q | new_fail;
    en       = load | active;
    if (load) begin
      pend_d = sel;
      fail_d = 1'b0;
    end else begin
      pend_d = pend_q & ~done;
      fail_d = any_fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      fail_q <= 1'b0;
    end else if (en) begin
      pend_q <= pend_d;
      fail_q <= fail_d;
    end
  end
endmodule

// File: rtl/stl_flags.sv
module stl_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic set_fail,
  input  logic clr_pass,
  input  logic clr_fail,
  output logic flag_pass,
  output logic flag_fail
);
  logic set_p, set_f, pass_d, fail_d;

  always_comb begin
    set_p  = set_evt && !set_fail;
    set_f  = set_evt && set_fail;
    pass_d = set_p ? 1'b1 : (clr_pass ? 1'b0 : flag_pass);
    fail_d = set_f ? 1'b1 : (clr_fail ? 1'b0 : flag_fail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_pass <= 1'b0;
      flag_fail <= 1'b0;
    end else begin
      flag_pass <= pass_d;
      flag_fail <= fail_d;
    end
  end
endmodule

// File: rtl/selftest_launch.sv
module selftest_launch
  import stl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_req,
  input  logic [PATH_W-1:0] entry_path,
  input  logic              nvm_fast_boot,
  input  logic              sw_fast_test,
  input  logic              lbist_failed_before,
  input  logic              crc_en,
  input  logic              vmon_en,
  input  logic              rt_req,
  input  logic [ENG_N-1:0]  eng_done,
  input  logic [ENG_N-1:0]  eng_pass,
  input  logic              clr_pass,
  input  logic              clr_fail,
  output logic [ENG_N-1:0]  eng_start,
  output logic              test_done,
  output logic              busy,
  output logic              if_ignore,
  output logic              flag_pass,
  output logic              flag_fail,
  output logic              int_n
);
  state_e           state_q, state_d;
  logic             rt_q, rt_d;
  logic [ENG_N-1:0] start_d, sel;
  logic             done_d, load, active, all_done, any_fail, finish;

  stl_skip_sel u_sel (
    .path               (entry_path),
    .runtime            (!boot_req),
    .nvm_fast_boot      (nvm_fast_boot),
    .sw_fast_test       (sw_fast_test),
    .lbist_failed_before(lbist_failed_before),
    .crc_en             (crc_en),
    .vmon_en            (vmon_en),
    .sel                (sel)
  );

  assign active = (state_q == ST_RUN);

  stl_collect u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .sel      (sel),
    .active   (active),
    .done     (eng_done),
    .pass     (eng_pass),
    .all_done (all_done),
    .any_fail (any_fail)
  );

  always_comb begin
    state_d = state_q;
    rt_d    = rt_q;
    load    = 1'b0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (boot_req || rt_req) begin
          load    = 1'b1;
          rt_d    = !boot_req;
          state_d = ST_RUN;
        end
      end
      default: begin
        if (all_done) begin
          finish  = 1'b1;
          rt_d    = 1'b0;
          state_d = ST_IDLE;
        end
      end
    endcase
    start_d = load ? sel : '0;
    done_d  = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rt_q      <= 1'b0;
      eng_start <= '0;
      test_done <= 1'b0;
    end else begin
      state_q   <= state_d;
      rt_q      <= rt_d;
      eng_start <= start_d;
      test_done <= done_d;
    end
  end

  stl_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (finish),
    .set_fail (any_fail),
    .clr_pass (clr_pass),
    .clr_fail (clr_fail),
    .flag_pass(flag_pass),
    .flag_fail(flag_fail)
  );

  assign busy      = active;
  assign if_ignore = active && rt_q;
  assign int_n     = !(flag_pass || flag_fail);
endmodule

// File: rtl/selftest_launch_chk.sv
module selftest_launch_chk
  import stl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [ENG_N-1:0] eng_start,
  input logic             test_done,
  input logic             busy,
  input logic             if_ignore,
  input logic             flag_pass,
  input logic             flag_fail,
  input logic             clr_pass,
  input logic             clr_fail,
  input logic             int_n
);
  assert_start_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_start) |-> $rose(busy));

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_start) |=> (eng_start == '0));

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |-> (!busy && $past(busy)));

  assert_ignore_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    if_ignore |-> busy);

  assert_done_raises_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |-> !int_n);

  assert_pass_clear_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_pass) |-> $past(clr_pass));

  assert_fail_clear_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_fail) |-> $past(clr_fail));
endmodule

bind selftest_launch selftest_launch_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .eng_start(eng_start),
  .test_done(test_done),
  .busy     (busy),
  .if_ignore(if_ignore),
  .flag_pass(flag_pass),
  .flag_fail(flag_fail),
  .clr_pass (clr_pass),
  .clr_fail (clr_fail),
  .int_n    (int_n)
);

// File: tb/selftest_launch_tb_top.sv
module selftest_launch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_req = 0, rt_req = 0;
  logic [1:0] entry_path = 2'b00;
  logic       nvm_fast_boot = 0, sw_fast_test = 0, lbist_failed_before = 0;
  logic       crc_en = 1, vmon_en = 1;
  logic [3:0] eng_done = 0, eng_pass = 0;
  logic       clr_pass = 0, clr_fail = 0;
  logic [3:0] eng_start;
  logic       test_done, busy, if_ignore, flag_pass, flag_fail, int_n;

  always #4 clk = ~clk;

  selftest_launch dut_i (.*);

  int vectors = 0, errors = 0, cycles = 0;
  int lat[4];
  bit pv[4];
  int cnt[4];
  logic [3:0] inj_done = 0, inj_pass = 0;
  logic [3:0] last_start = 0;
  int starts_seen = 0;
  bit ignore_seen = 0;

  // behavioural reference state
  bit m_busy, m_rt, m_done, m_fail, m_fp, m_ff;
  logic [3:0] m_start, m_pend;

  function automatic logic [3:0] exp_mask(bit rt, logic [1:0] p, bit fb, bit sw,
                                          bit prev, bit crc, bit vm);
    bit lg;
    if (rt) lg = 1;
    else if (p == 2'b01) lg = !sw;
    else if (p == 2'b10) lg = prev;
    else lg = !fb;
    return {vm, crc, 1'b1, lg};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_rt = 0; m_done = 0; m_fail = 0; m_fp = 0; m_ff = 0;
      m_start = 0; m_pend = 0;
    end else begin
      bit sp, sf;
      sp = 0; sf = 0;
      m_start = 0; m_done = 0;
      if (m_busy) begin
        if ((m_pend & eng_done & ~eng_pass) != 0) m_fail = 1;
        m_pend = m_pend & ~eng_done;
        if (m_pend == 0) begin
          m_busy = 0; m_rt = 0; m_done = 1;
          if (m_fail) sf = 1; else sp = 1;
        end
      end else if (boot_req || rt_req) begin
        m_rt    = !boot_req;
        m_start = exp_mask(m_rt, entry_path, nvm_fast_boot, sw_fast_test,
                           lbist_failed_before, crc_en, vmon_en);
        m_pend  = m_start;
        m_fail  = 0;
        m_busy  = 1;
      end
      m_fp = sp ? 1'b1 : (clr_pass ? 1'b0 : m_fp);
      m_ff = sf ? 1'b1 : (clr_fail ? 1'b0 : m_ff);
    end
  end

  // per-cycle comparison and engine stubs, away from the rising edge
  always @(negedge clk) begin
    logic [3:0] dv, pvv;
    cycles++;
    chk(eng_start == m_start, "R6", "eng_start", eng_start, m_start);
    chk(test_done == m_done, "R7", "test_done", test_done, m_done);
    chk(busy == m_busy, "R11", "busy", busy, m_busy);
    chk(if_ignore == (m_busy && m_rt), "R9", "if_ignore", if_ignore, m_busy && m_rt);
    chk({flag_pass, flag_fail} == {m_fp, m_ff}, "R10", "flags",
        {flag_pass, flag_fail}, {m_fp, m_ff});
    chk(int_n == !(m_fp || m_ff), "R10", "int_n", int_n, !(m_fp || m_ff));
    if (eng_start != 0) begin last_start = eng_start; starts_seen++; end
    if (if_ignore) ignore_seen = 1;
    dv = 0; pvv = 0;
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) cnt[i] = 0;
      else begin
        if (cnt[i] == 1) begin dv[i] = 1; pvv[i] = pv[i]; end
        if (cnt[i] > 0) cnt[i]--;
        if (eng_start[i]) cnt[i] = lat[i];
      end
    end
    eng_done <= dv | inj_done;
    eng_pass <= pvv | (inj_done & inj_pass);
  end

  task automatic wait_done();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (test_done) break;
    end
    @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_pass = 1; clr_fail = 1;
    @(negedge clk); clr_pass = 0; clr_fail = 0;
    @(negedge clk);
  endtask

  task automatic run(bit rt, logic [1:0] p, bit fb, bit sw, bit prev, bit crc,
                     bit vm, string req, bit exp_pass);
    logic [3:0] em;
    em = exp_mask(rt, p, fb, sw, prev, crc, vm);
    @(negedge clk);
    entry_path = p; nvm_fast_boot = fb; sw_fast_test = sw;
    lbist_failed_before = prev; crc_en = crc; vmon_en = vm;
    boot_req = !rt; rt_req = rt;
    @(negedge clk);
    boot_req = 0; rt_req = 0;
    wait_done();
    chk(last_start == em, req, "start mask", last_start, em);
    chk(flag_pass == exp_pass && flag_fail == !exp_pass, "R8", "result",
        {flag_pass, flag_fail}, {exp_pass, !exp_pass});
    clear_flags();
  endtask

  initial begin
    lat[0] = 3; lat[1] = 7; lat[2] = 5; lat[3] = 2;
    for (int i = 0; i < 4; i++) begin pv[i] = 1; cnt[i] = 0; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && int_n == 1 && eng_start == 0, "R1", "reset outputs",
        {busy, int_n, eng_start}, 6'b010000);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && int_n == 1 && test_done == 0, "R1", "after reset",
        {busy, int_n, test_done}, 3'b010);
    run(0, 2'b00, 0, 1, 1, 1, 1, "R2", 1);
    run(0, 2'b00, 1, 0, 1, 1, 1, "R2", 1);
    run(0, 2'b11, 1, 0, 0, 1, 1, "R2", 1);
    run(0, 2'b01, 1, 0, 0, 1, 1, "R3", 1);
    run(0, 2'b01, 0, 1, 0, 1, 1, "R3", 1);
    run(0, 2'b10, 0, 0, 0, 1, 1, "R4", 1);
    run(0, 2'b10, 1, 1, 1, 1, 1, "R4", 1);
    run(0, 2'b00, 0, 0, 0, 0, 1, "R5", 1);
    run(0, 2'b00, 0, 0, 0, 1, 0, "R5", 1);
    // slowest engine dominates completion (R7)
    lat[3] = 20;
    run(0, 2'b00, 0, 0, 0, 1, 1, "R7", 1);
    lat[3] = 2;
    // one started engine fails (R8)
    pv[2] = 0;
    run(0, 2'b00, 0, 0, 0, 1, 1, "R8", 0);
    pv[2] = 1;
    // skipped logic engine reports a failure: ignored (R8)
    fork
      run(0, 2'b00, 1, 0, 0, 1, 1, "R8", 1);
      begin
        repeat (4) @(negedge clk);
        inj_done = 4'b0001; inj_pass = 0;
        @(negedge clk); inj_done = 0;
      end
    join
    // runtime test ignores skip bits and raises if_ignore (R9)
    ignore_seen = 0;
    run(1, 2'b10, 1, 1, 0, 1, 1, "R9", 1);
    chk(ignore_seen, "R9", "if_ignore seen", ignore_seen, 1);
    // requests while busy are ignored (R11)
    starts_seen = 0;
    fork
      run(0, 2'b00, 0, 0, 0, 1, 1, "R11", 1);
      begin
        repeat (4) @(negedge clk);
        rt_req = 1;
        @(negedge clk); rt_req = 0;
      end
    join
    chk(starts_seen == 1, "R11", "start count", starts_seen, 1);
    // simultaneous boot and runtime: boot wins (R11)
    ignore_seen = 0;
    @(negedge clk); entry_path = 2'b00; nvm_fast_boot = 1;
    boot_req = 1; rt_req = 1;
    @(negedge clk); boot_req = 0; rt_req = 0;
    wait_done();
    chk(last_start == 4'b1110 && !ignore_seen, "R11", "boot priority",
        {ignore_seen, last_start}, 5'b01110);
    // write-1-to-clear, one flag at a time (R10)
    @(negedge clk); clr_fail = 1;
    @(negedge clk); clr_fail = 0;
    @(negedge clk);
    chk(flag_pass == 1 && int_n == 0, "R10", "clr_fail keeps pass",
        {flag_pass, int_n}, 2'b10);
    @(negedge clk); clr_pass = 1;
    @(negedge clk); clr_pass = 0;
    @(negedge clk);
    chk(flag_pass == 0 && int_n == 1, "R10", "clr_pass releases int",
        {flag_pass, int_n}, 2'b01);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule